// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block sits in the feedback path of a frequency-synthesizer loop. It divides a fast clock by a 15-bit ratio word. A prescaler alternates between divide-by-16 and divide-by-17, and two counters steer it. The ratio word is split into a main count M (bits 14..4) and a swallow count A (bits 3..0), so one output period lasts 16·M + A input clocks. Once per period the block emits a single-clock pulse. A second output toggles on every pulse, giving a half-rate square wave that a test multiplexer can route to a pin.

A new ratio word arrives with a one-cycle load strobe and is held as pending. The counters take the pending word only when the current output period ends, so a period is never cut short. A word below the legal floor of 240 is raised to 240 and flagged.

Top module: `pswallow_divider`

## Requirements
- R1: For a loaded word W in 240..32767, with M = W[14:4] and A = W[3:0], successive output pulses are exactly 16·M + A input clocks apart (for example 240, 1000, 32767).
- R2: Within each output period the prescaler divides by 17 for its first A cycles and by 16 for the rest, so words that differ only in A (240, 241, 255) differ in period by exactly that amount.
- R3: Every legal word satisfies M ≥ A. This includes the case M = A = 15 (word 255), which gives a period of 255.
- R4: A loaded word below 240 is replaced by 240 and `ratio_err_o` is set from the clock after the load. Loading a word of 240 or more clears `ratio_err_o`. The value 239 is flagged and the value 240 is not.
- R5: A word loaded partway through a period does not change that period. It governs the next one. A load that falls in the same clock as the end of a period governs the period that starts immediately.
- R6: `div_pulse_o` is high for exactly one clock per output period.
- R7: `div_half_o` toggles on the same clock edge that raises `div_pulse_o`. It is 0 after reset.
- R8: After reset, `div_pulse_o`, `div_half_o` and `ratio_err_o` are 0, and the active ratio is 240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ratio_i | input | 15 | Requested division ratio |
| load_i | input | 1 | One-clock strobe that captures ratio_i |
| div_pulse_o | output | 1 | One-clock pulse per output period |
| div_half_o | output | 1 | Output that toggles on every pulse |
| ratio_err_o | output | 1 | The last loaded word was below 240 |

## Verification
The delicate collision is a load strobe that arrives in the very clock in which the counters reach the end of a period and reload. The bench counts clocks from the previous pulse and places the strobe exactly one clock before the next period would close. It then judges that the period just finishing keeps the old length, and that the following period already has the new length rather than being delayed by one period. Strobes placed well inside a period give the contrasting case, where the first period after the strobe must still show the old length.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int RATIO_W   = 15;
  localparam int SWAL_W    = 4;
  localparam int MAIN_W    = RATIO_W - SWAL_W;
  localparam int PRE_DIV   = 1 << SWAL_W;
  localparam int PRE_W     = SWAL_W + 1;
  localparam int MIN_RATIO = 240;

  typedef logic [RATIO_W-1:0] ratio_t;

  function automatic logic ratio_low(ratio_t r);
    return r < RATIO_W'(MIN_RATIO);
  endfunction

  function automatic ratio_t ratio_clamp(ratio_t r);
    return ratio_low(r) ? RATIO_W'(MIN_RATIO) : r;
  endfunction

  function automatic logic [MAIN_W-1:0] main_of(ratio_t r);
    return r[RATIO_W-1:SWAL_W];
  endfunction

  function automatic logic [SWAL_W-1:0] swal_of(ratio_t r);
    return r[SWAL_W-1:0];
  endfunction
endpackage

// File: rtl/pswallow_ratio_reg.sv
module pswallow_ratio_reg
  import pswallow_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t ratio_i,
  input  logic   load_i,
  output ratio_t next_ratio_o,
  output logic   err_o
);
  ratio_t pending_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pending_q <= RATIO_W'(MIN_RATIO);
      err_o     <= 1'b0;
    end else if (load_i) begin
      pending_q <= ratio_clamp(ratio_i);
      err_o     <= ratio_low(ratio_i);
    end
  end

  // a strobe in the reload clock takes effect at once
  assign next_ratio_o = load_i ? ratio_clamp(ratio_i) : pending_q;

  AST_PENDING_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q >= RATIO_W'(MIN_RATIO)); // R4
  AST_ERR_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (ratio_i < RATIO_W'(MIN_RATIO)) |=> err_o); // R4
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (ratio_i >= RATIO_W'(MIN_RATIO)) |=> !err_o); // R4
endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
  import pswallow_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic swallow_i,
  output logic wrap_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last_val;

  assign last_val = swallow_i ? PRE_W'(PRE_DIV) : PRE_W'(PRE_DIV - 1);
  assign wrap_o   = (cnt_q == last_val);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PRE_W'(PRE_DIV)); // R2
  AST_PRE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swallow_i |-> cnt_q <= PRE_W'(PRE_DIV - 1)); // R2
endmodule

// File: rtl/pswallow_counters.sv
module pswallow_counters
  import pswallow_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pre_wrap_i,
  input  ratio_t next_ratio_i,
  output logic   swallow_o,
  output logic   cyc_end_o
);
  logic [MAIN_W-1:0] main_q;
  logic [SWAL_W-1:0] swal_q;

  assign swallow_o = (swal_q != '0);
  assign cyc_end_o = pre_wrap_i && (main_q == MAIN_W'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      main_q <= main_of(RATIO_W'(MIN_RATIO));
      swal_q <= swal_of(RATIO_W'(MIN_RATIO));
    end else if (cyc_end_o) begin
      main_q <= main_of(next_ratio_i);
      swal_q <= swal_of(next_ratio_i);
    end else if (pre_wrap_i) begin
      main_q <= main_q - 1'b1;
      if (swallow_o) swal_q <= swal_q - 1'b1;
    end
  end

  AST_MAIN_GE_SWAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    MAIN_W'(swal_q) <= main_q); // R3
  AST_HOLD_MIDCYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_wrap_i |=> $stable(main_q) && $stable(swal_q)); // R5
  AST_MAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_wrap_i && !cyc_end_o |=> main_q == $past(main_q) - 1'b1); // R1
  AST_MAIN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_q != '0); // R1
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
  import pswallow_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               load_i,
  output logic               div_pulse_o,
  output logic               div_half_o,
  output logic               ratio_err_o
);
  ratio_t next_ratio;
  logic   pre_wrap;
  logic   swallow_on;
  logic   cyc_end;

  pswallow_ratio_reg u_ratio (
    .clk_i(clk_i), .rst_ni(rst_ni), .ratio_i(ratio_i), .load_i(load_i),
    .next_ratio_o(next_ratio), .err_o(ratio_err_o)
  );

  pswallow_prescaler u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .swallow_i(swallow_on), .wrap_o(pre_wrap)
  );

  pswallow_counters u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pre_wrap_i(pre_wrap),
    .next_ratio_i(next_ratio), .swallow_o(swallow_on), .cyc_end_o(cyc_end)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_pulse_o <= 1'b0;
      div_half_o  <= 1'b0;
    end else begin
      div_pulse_o <= cyc_end;
      div_half_o  <= div_half_o ^ cyc_end;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o); // R6
  AST_HALF_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_end |=> div_half_o != $past(div_half_o)); // R7
  AST_HALF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_end |=> $stable(div_half_o)); // R7
endmodule

// File: tb/pswallow_divider_tb.sv
module pswallow_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] ratio = '0;
  logic        load = 1'b0;
  logic        pulse, half, err;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        exp_half = 1'b0;

  always #10 clk = ~clk;

  pswallow_divider dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .load_i(load),
    .div_pulse_o(pulse), .div_half_o(half), .ratio_err_o(err)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int w);
    int v = (w < 240) ? 240 : w;
    return (v / 16) * 16 + (v % 16);
  endfunction

  // counts clocks to the next pulse; optional load at clock k
  task automatic measure(input int k, input int w, output int len);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == k) begin ratio = w[14:0]; load = 1'b1; end
      else load = 1'b0;
      if (n == 1) check(!pulse, "R6 pulse width", int'(pulse), 0);
    end while (!pulse && n < 40000);
    load = 1'b0;
    exp_half = ~exp_half;
    check(half == exp_half, "R7 half toggle", int'(half), int'(exp_half));
    len = n;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pulse, "R8 pulse reset", int'(pulse), 0);
    check(!half, "R8 half reset", int'(half), 0);
    check(!err, "R8 err reset", int'(err), 0);
    while (!pulse) @(negedge clk);
    exp_half = 1'b1;
  endtask

  task automatic t_default();
    int len;
    measure(0, 0, len);
    check(len == 240, "R8 R1 default period", len, 240);
  endtask

  // load mid-period: current unchanged, next one new
  task automatic t_load(input int w, input int old_p, input string req);
    int len;
    measure(7, w, len);
    check(len == old_p, "R5 current period kept", len, old_p);
    check(err == (w < 240), "R4 error flag", int'(err), int'(w < 240));
    measure(0, 0, len);
    check(len == period_of(w), req, len, period_of(w));
  endtask

  task automatic t_coincide(input int w, input int old_p);
    int len;
    measure(old_p - 1, w, len);
    check(len == old_p, "R5 boundary load old period", len, old_p);
    measure(0, 0, len);
    check(len == period_of(w), "R5 boundary load immediate", len, period_of(w));
  endtask

  initial begin
    t_reset();
    t_default();
    t_load(1000, 240, "R1 ratio 1000");
    t_load(241, 1000, "R2 swallow one");
    t_load(255, 241, "R3 M equals A");
    t_load(100, 255, "R4 clamp 100");
    t_load(239, 240, "R4 clamp 239");
    t_load(240, 240, "R4 floor 240");
    check(!err, "R4 error cleared", int'(err), 0);
    t_load(1000, 240, "R1 ratio 1000 again");
    t_coincide(500, 1000);
    t_load(32767, 500, "R1 ratio max");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule